// File: doc/BRIEF.md
# Addressed Peripheral Controller with Busy/Done Status and Maskable Interrupt

This block is one device slot on a shared CPU I/O bus. Each bus cycle carries a device address, a 3-bit transfer opcode, a 2-bit control field and a write data word. When the address matches the slot's configured address, the controller does one of three things. It can load or return one of up to three data registers. It can act on a control strobe (start, clear or pulse). It can answer a status-sense query with a single skip bit.

On the device side, a start tells the attached peripheral that work is wanted, through a one-cycle `dev_go` pulse. A completion input from the peripheral ends the operation. The Busy and Done flags follow fixed transition rules. A completion can latch an interrupt request, but only while interrupts are enabled for the slot. Interrupt enable is loaded by a separate, unaddressed mask-load strobe.

The read data and the skip bit are combinational. They are valid in the same cycle as the request. All state updates on the rising clock edge that ends the bus cycle.

Top module: `iodev_ctrl`

## Requirements
- R1: The block acts only in a cycle with `bus_cyc`=1 and `bus_addr` equal to `DEV_ADDR`. In any other cycle no register changes, no strobe takes effect, and `bus_rdata` and `bus_skip` are 0.
- R2: Opcodes 2, 4 and 6 load registers A, B and C (indices 0, 1 and 2) from `bus_wdata` at the clock edge. Register i appears on `dev_regs[i*DATA_W +: DATA_W]`.
- R3: Opcodes 1, 3 and 5 drive register A, B or C onto `bus_rdata` in the same cycle. Otherwise `bus_rdata` is 0. A register whose index is `NUM_REGS` or above reads as 0 and ignores writes.
- R4: Control field 01 (start) with any opcode other than 7 gives busy=1, done=0 and irq=0 after the edge. It also raises `dev_go` for exactly one cycle.
- R5: Control field 10 (clear) with any opcode other than 7 gives busy=0, done=0 and irq=0 after the edge.
- R6: Control field 11 (pulse) with any opcode other than 7 raises `dev_pulse` for one cycle and leaves busy and done unchanged.
- R7: `dev_cmpl` while busy=1 gives busy=0 and done=1. `dev_cmpl` while busy=0 is ignored. A clear or start in the same cycle overrides the completion.
- R8: A completion sets irq only if interrupts were enabled before that edge. irq then stays set until a start or clear.
- R9: `mask_ld` loads the interrupt enable from `mask_val` whatever the address. Changing the enable leaves a pending irq as it is.
- R10: Opcode 7 is a status sense and no strobe. Its control field selects `bus_skip`: 00 gives busy, 01 gives not busy, 10 gives done, 11 gives not done.
- R11: A register write and a strobe in the same cycle both take effect at the same edge.
- R12: After reset, busy, done, irq, interrupt enable, `dev_go`, `dev_pulse` and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_addr | input | ADDR_W | Device address on the bus |
| bus_op | input | 3 | Transfer opcode |
| bus_ctl | input | 2 | Control strobe or sense condition |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| bus_skip | output | 1 | Status-sense result, combinational |
| mask_ld | input | 1 | Interrupt enable load strobe |
| mask_val | input | 1 | Interrupt enable value |
| dev_cmpl | input | 1 | Peripheral completion |
| dev_go | output | 1 | One-cycle start request to the peripheral |
| dev_pulse | output | 1 | One-cycle device-defined action |
| dev_regs | output | NUM_REGS*DATA_W | Register contents for the peripheral |
| busy | output | 1 | Busy flag |
| done | output | 1 | Done flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two slots on one shared bus. The first has `NUM_REGS`=3 and `DEV_ADDR`=37, which exercises the full register set together with all strobe, completion and interrupt orderings. The second has `NUM_REGS`=2 and `DEV_ADDR`=63. The all-ones address checks the comparator at its upper edge. The missing register C shows that an absent slot reads 0 after a write, while the neighbouring slot on the same bus stays untouched.

// File: rtl/iodev_pkg.sv
// Package: shared encodings of the peripheral controller's bus fields.
// Assumes a 3-bit opcode and a 2-bit control field, as decoded by iodev_decode.
package iodev_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_RD_A  = 3'd1,
        OP_WR_A  = 3'd2,
        OP_RD_B  = 3'd3,
        OP_WR_B  = 3'd4,
        OP_RD_C  = 3'd5,
        OP_WR_C  = 3'd6,
        OP_SENSE = 3'd7
    } bus_op_e;

    typedef enum logic [1:0] {
        CTL_NONE  = 2'd0,
        CTL_START = 2'd1,
        CTL_CLEAR = 2'd2,
        CTL_PULSE = 2'd3
    } bus_ctl_e;

    typedef enum logic [1:0] {
        SNS_BUSY     = 2'd0,
        SNS_IDLE     = 2'd1,
        SNS_DONE     = 2'd2,
        SNS_NOT_DONE = 2'd3
    } sense_e;

    localparam int MAX_REGS = 3;
endpackage

// File: rtl/iodev_decode.sv
// Module: iodev_decode
// Purely combinational. Compares the bus address with the slot address and
// splits the opcode and control field into write enables, a read select,
// strobe events and a sense request. Assumes 1 <= NUM_REGS <= MAX_REGS.
module iodev_decode
    import iodev_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter int unsigned DEV_ADDR = 0,
    parameter int          NUM_REGS = 3
) (
    input  logic              bus_cyc,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_op,
    input  logic [1:0]        bus_ctl,
    output logic              sel,
    output logic [NUM_REGS-1:0] wr_en,
    output logic              rd_en,
    output logic [1:0]        rd_idx,
    output logic              sense_en,
    output logic [1:0]        sense_cond,
    output logic              start_evt,
    output logic              clear_evt,
    output logic              pulse_evt
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DEV_ADDR);

    bus_op_e  op;
    bus_ctl_e ctl;
    logic     strobe_ok;

    // Purpose: address match and opcode typing.
    always_comb begin
        op        = bus_op_e'(bus_op);
        ctl       = bus_ctl_e'(bus_ctl);
        sel       = bus_cyc && (bus_addr == MY_ADDR);
        sense_en  = sel && (op == OP_SENSE);
        strobe_ok = sel && (op != OP_SENSE);
    end

    // Purpose: one write enable per implemented register.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_wen
        localparam logic [2:0] WR_CODE = 3'(2 * (i + 1));
        always_comb wr_en[i] = sel && (bus_op == WR_CODE);
    end

    // Purpose: read select from odd opcodes other than the sense code.
    always_comb begin
        rd_en  = sel && bus_op[0] && (op != OP_SENSE);
        rd_idx = bus_op[2:1];
    end

    // Purpose: control strobes, suppressed while the field carries a sense condition.
    always_comb begin
        start_evt  = strobe_ok && (ctl == CTL_START);
        clear_evt  = strobe_ok && (ctl == CTL_CLEAR);
        pulse_evt  = strobe_ok && (ctl == CTL_PULSE);
        sense_cond = bus_ctl;
    end
endmodule

// File: rtl/iodev_regs.sv
// Module: iodev_regs
// The data registers, each loaded from the write bus when its enable is set.
// Assumes at most one enable is set per cycle (the decoder guarantees it).
module iodev_regs #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_REGS-1:0]             wr_en,
    input  logic [DATA_W-1:0]               wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0] q
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // Purpose: hold register i, loading it on its write enable.
        always_ff @(posedge clk) begin
            if (!rst_n)        q[i] <= '0;
            else if (wr_en[i]) q[i] <= wdata;
        end

        a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[i] |=> q[i] == $past(wdata));
        a_r1_hold_unless_written: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[i] |=> $stable(q[i]));
    end
endmodule

// File: rtl/iodev_status.sv
// Module: iodev_status
// Busy/Done flags, the interrupt enable, the interrupt request latch and the
// one-cycle peripheral strobes. Priority is clear, then start, then completion.
// Assumes its event inputs are already qualified by the address match.
module iodev_status (
    input  logic clk,
    input  logic rst_n,
    input  logic start_evt,
    input  logic clear_evt,
    input  logic pulse_evt,
    input  logic cmpl,
    input  logic mask_ld,
    input  logic mask_val,
    output logic busy,
    output logic done,
    output logic irq,
    output logic int_en,
    output logic go,
    output logic pulse_o
);
    logic finish;

    // Purpose: a completion counts only while an operation is in flight.
    always_comb finish = cmpl && busy;

    // Purpose: the Busy/Done pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else if (clear_evt) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else if (start_evt) begin
            busy <= 1'b1;
            done <= 1'b0;
        end else if (finish) begin
            busy <= 1'b0;
            done <= 1'b1;
        end
    end

    // Purpose: the interrupt latch, set by an enabled completion and cleared by start or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                      irq <= 1'b0;
        else if (clear_evt || start_evt) irq <= 1'b0;
        else if (finish && int_en)       irq <= 1'b1;
    end

    // Purpose: the interrupt enable, loaded by the mask strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       int_en <= 1'b0;
        else if (mask_ld) int_en <= mask_val;
    end

    // Purpose: registered one-cycle strobes towards the peripheral.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go      <= 1'b0;
            pulse_o <= 1'b0;
        end else begin
            go      <= start_evt;
            pulse_o <= pulse_evt;
        end
    end

    a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !clear_evt) |=> busy && !done && !irq && go);
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_evt |=> !busy && !done && !irq);
    a_r6_pulse_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_evt && !cmpl) |=> pulse_o && $stable(busy) && $stable(done));
    a_r7_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl && busy && !start_evt && !clear_evt) |=> !busy && done);
    a_r7_idle_cmpl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl && !busy && !start_evt && !clear_evt) |=> $stable(done) && !busy);
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(int_en) && done);
    a_r9_mask_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_ld && irq && !start_evt && !clear_evt) |=> irq);
endmodule

// File: rtl/iodev_ctrl.sv
// Module: iodev_ctrl (top)
// One addressed peripheral slot: decoder, data registers, status/interrupt
// logic, plus the combinational read mux and sense result.
// Assumes one bus request per cycle and 1 <= NUM_REGS <= 3.
module iodev_ctrl
    import iodev_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter int          ADDR_W   = 6,
    parameter int unsigned DEV_ADDR = 37,
    parameter int          NUM_REGS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_cyc,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [2:0]                 bus_op,
    input  logic [1:0]                 bus_ctl,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       bus_skip,
    input  logic                       mask_ld,
    input  logic                       mask_val,
    input  logic                       dev_cmpl,
    output logic                       dev_go,
    output logic                       dev_pulse,
    output logic [NUM_REGS*DATA_W-1:0] dev_regs,
    output logic                       busy,
    output logic                       done,
    output logic                       irq
);
    logic                            sel, rd_en, sense_en;
    logic                            start_evt, clear_evt, pulse_evt;
    logic [NUM_REGS-1:0]             wr_en;
    logic [1:0]                      rd_idx, sense_cond;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic                            int_en;

    iodev_decode #(
        .ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)
    ) u_decode (
        .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_op(bus_op), .bus_ctl(bus_ctl),
        .sel(sel), .wr_en(wr_en), .rd_en(rd_en), .rd_idx(rd_idx),
        .sense_en(sense_en), .sense_cond(sense_cond),
        .start_evt(start_evt), .clear_evt(clear_evt), .pulse_evt(pulse_evt)
    );

    iodev_regs #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(bus_wdata), .q(regs_q)
    );

    iodev_status u_status (
        .clk(clk), .rst_n(rst_n),
        .start_evt(start_evt), .clear_evt(clear_evt), .pulse_evt(pulse_evt),
        .cmpl(dev_cmpl), .mask_ld(mask_ld), .mask_val(mask_val),
        .busy(busy), .done(done), .irq(irq), .int_en(int_en),
        .go(dev_go), .pulse_o(dev_pulse)
    );

    // Purpose: expose the register contents to the peripheral.
    assign dev_regs = regs_q;

    // Purpose: read mux; absent registers and idle cycles return zero.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_en && rd_idx == 2'(i)) bus_rdata = regs_q[i];
        end
    end

    // Purpose: status-sense result selected by the control field.
    always_comb begin
        bus_skip = 1'b0;
        if (sense_en) begin
            unique case (sense_e'(sense_cond))
                SNS_BUSY:     bus_skip = busy;
                SNS_IDLE:     bus_skip = !busy;
                SNS_DONE:     bus_skip = done;
                SNS_NOT_DONE: bus_skip = !done;
            endcase
        end
    end

    a_r1_quiet_when_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (bus_rdata == '0) && !bus_skip && (wr_en == '0));
    a_r10_sense_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_en && !dev_cmpl) |=> $stable(busy) && $stable(done) && !dev_go && !dev_pulse);
    a_r9_enable_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_ld |=> int_en == $past(mask_val));
endmodule

// File: tb/iodev_ctrl_tb.sv
module iodev_ctrl_tb_top;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_cyc = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [2:0]    bus_op = '0;
    logic [1:0]    bus_ctl = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          mask_ld = 1'b0, mask_val = 1'b0, dev_cmpl = 1'b0;

    logic [DW-1:0]   rdata1, rdata2;
    logic            skip1, skip2, go1, go2, pu1, pu2, busy1, busy2, done1, done2, irq1, irq2;
    logic [3*DW-1:0] regs1;
    logic [2*DW-1:0] regs2;

    always #5 clk = ~clk;

    iodev_ctrl #(.DATA_W(DW), .ADDR_W(6), .DEV_ADDR(37), .NUM_REGS(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_op(bus_op),
        .bus_ctl(bus_ctl), .bus_wdata(bus_wdata), .bus_rdata(rdata1), .bus_skip(skip1),
        .mask_ld(mask_ld), .mask_val(mask_val), .dev_cmpl(dev_cmpl), .dev_go(go1),
        .dev_pulse(pu1), .dev_regs(regs1), .busy(busy1), .done(done1), .irq(irq1));

    iodev_ctrl #(.DATA_W(DW), .ADDR_W(6), .DEV_ADDR(63), .NUM_REGS(2)) dut2_i (
        .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_op(bus_op),
        .bus_ctl(bus_ctl), .bus_wdata(bus_wdata), .bus_rdata(rdata2), .bus_skip(skip2),
        .mask_ld(mask_ld), .mask_val(mask_val), .dev_cmpl(1'b0), .dev_go(go2),
        .dev_pulse(pu2), .dev_regs(regs2), .busy(busy2), .done(done2), .irq(irq2));

    typedef struct packed {
        logic [DW-1:0]   rd;
        logic            skip;
        logic            busy, done, irq, go, pu;
        logic [3*DW-1:0] regs;
        logic [DW-1:0]   rd2;
    } item_t;

    item_t exp_q[$];
    string req_q[$];
    int    n_chk = 0, n_fail = 0;

    // bench model of the first slot, built from the requirements
    logic [DW-1:0] m_r[3];
    logic [DW-1:0] m2[2];
    logic          m_b = 0, m_d = 0, m_i = 0, m_en = 0;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // driver: apply one bus cycle and push what the design must show
    task automatic do_cyc(input logic [5:0] a, input logic [2:0] op, input logic [1:0] ctl,
                          input logic [DW-1:0] wd, input logic cm, input logic mld,
                          input logic mv, input string req);
        item_t it;
        logic s1, s2, st, cl, pu, fin;
        @(negedge clk);
        bus_cyc = 1; bus_addr = a; bus_op = op; bus_ctl = ctl; bus_wdata = wd;
        dev_cmpl = cm; mask_ld = mld; mask_val = mv;
        s1 = (a == 6'd37); s2 = (a == 6'd63);
        it = '0;
        if (s1 && op inside {3'd1, 3'd3, 3'd5}) it.rd = m_r[op >> 1];
        if (s2 && op == 3'd1) it.rd2 = m2[0];
        if (s2 && op == 3'd3) it.rd2 = m2[1];
        if (s1 && op == 3'd7)
            case (ctl)
                2'd0: it.skip = m_b;
                2'd1: it.skip = !m_b;
                2'd2: it.skip = m_d;
                default: it.skip = !m_d;
            endcase
        if (s1 && op inside {3'd2, 3'd4, 3'd6}) m_r[(op >> 1) - 1] = wd;
        if (s2 && op == 3'd2) m2[0] = wd;
        if (s2 && op == 3'd4) m2[1] = wd;
        st = s1 && op != 3'd7 && ctl == 2'd1;
        cl = s1 && op != 3'd7 && ctl == 2'd2;
        pu = s1 && op != 3'd7 && ctl == 2'd3;
        fin = cm && m_b;
        if (cl) begin m_b = 0; m_d = 0; m_i = 0; end
        else if (st) begin m_b = 1; m_d = 0; m_i = 0; end
        else if (fin) begin m_b = 0; m_d = 1; if (m_en) m_i = 1; end
        if (mld) m_en = mv;
        it.busy = m_b; it.done = m_d; it.irq = m_i; it.go = st; it.pu = pu;
        it.regs = {m_r[2], m_r[1], m_r[0]};
        exp_q.push_back(it);
        req_q.push_back(req);
    endtask

    // monitor: compare combinational outputs before the edge, state after it
    initial begin
        item_t it;
        string rq;
        forever begin
            @(negedge clk);
            #4;
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                rq = req_q.pop_front();
                chk(rdata1 === it.rd, rq, "rdata", 64'(rdata1), 64'(it.rd));
                chk(skip1 === it.skip, rq, "skip", 64'(skip1), 64'(it.skip));
                chk(rdata2 === it.rd2, rq, "rdata2", 64'(rdata2), 64'(it.rd2));
                @(posedge clk);
                #1;
                chk({busy1, done1, irq1} === {it.busy, it.done, it.irq}, rq, "busy/done/irq",
                    64'({busy1, done1, irq1}), 64'({it.busy, it.done, it.irq}));
                chk({go1, pu1} === {it.go, it.pu}, rq, "go/pulse",
                    64'({go1, pu1}), 64'({it.go, it.pu}));
                chk(regs1 === it.regs, rq, "regs", 64'(regs1), 64'(it.regs));
            end
        end
    end

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) m_r[i] = '0;
        for (int i = 0; i < 2; i++) m2[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #4;
        // R12: reset state
        chk({busy1, done1, irq1, go1, pu1} === 5'b0, "R12", "flags",
            64'({busy1, done1, irq1, go1, pu1}), 64'd0);
        chk(regs1 === '0, "R12", "regs", 64'(regs1), 64'd0);
        do_cyc(6'd37, 3'd1, 2'd0, 16'h0, 0, 0, 0, "R12");
        do_cyc(6'd37, 3'd7, 2'd2, 16'h0, 0, 0, 0, "R12");          // done clear at reset
        do_cyc(6'd0, 3'd0, 2'd0, 16'h0, 1, 0, 0, "R12");           // enable is 0 at reset

        do_cyc(6'd37, 3'd2, 2'd0, 16'hF400, 0, 0, 0, "R2");
        do_cyc(6'd37, 3'd1, 2'd0, 16'h0, 0, 0, 0, "R3");
        do_cyc(6'd37, 3'd4, 2'd0, 16'h1234, 0, 0, 0, "R2");
        do_cyc(6'd37, 3'd6, 2'd0, 16'hBEEF, 0, 0, 0, "R2");
        do_cyc(6'd37, 3'd3, 2'd0, 16'h0, 0, 0, 0, "R3");
        do_cyc(6'd37, 3'd5, 2'd0, 16'h0, 0, 0, 0, "R3");

        do_cyc(6'd36, 3'd2, 2'd0, 16'h0001, 0, 0, 0, "R1");        // wrong address write
        do_cyc(6'd36, 3'd1, 2'd0, 16'h0, 0, 0, 0, "R1");
        do_cyc(6'd38, 3'd0, 2'd1, 16'h0, 0, 0, 0, "R1");           // wrong address start
        do_cyc(6'd36, 3'd7, 2'd1, 16'h0, 0, 0, 0, "R1");

        do_cyc(6'd37, 3'd7, 2'd1, 16'h0, 0, 0, 0, "R10");          // not busy -> 1
        do_cyc(6'd37, 3'd7, 2'd0, 16'h0, 0, 0, 0, "R10");          // busy -> 0
        do_cyc(6'd5, 3'd0, 2'd0, 16'h0, 0, 1, 1, "R9");            // unaddressed mask load

        do_cyc(6'd37, 3'd0, 2'd1, 16'h0, 0, 0, 0, "R4");
        do_cyc(6'd37, 3'd7, 2'd0, 16'h0, 0, 0, 0, "R10");
        do_cyc(6'd37, 3'd7, 2'd1, 16'h0, 0, 0, 0, "R10");
        do_cyc(6'd37, 3'd0, 2'd3, 16'h0, 0, 0, 0, "R6");
        do_cyc(6'd0, 3'd0, 2'd0, 16'h0, 1, 0, 0, "R7");            // completion, irq on
        do_cyc(6'd37, 3'd7, 2'd2, 16'h0, 0, 0, 0, "R10");
        do_cyc(6'd37, 3'd7, 2'd3, 16'h0, 0, 0, 0, "R10");
        do_cyc(6'd0, 3'd0, 2'd0, 16'h0, 0, 1, 0, "R9");            // disable keeps irq
        do_cyc(6'd37, 3'd4, 2'd1, 16'h5555, 0, 0, 0, "R11");       // write + start
        do_cyc(6'd0, 3'd0, 2'd0, 16'h0, 1, 0, 0, "R8");            // disabled completion
        do_cyc(6'd37, 3'd0, 2'd2, 16'h0, 0, 0, 0, "R5");
        do_cyc(6'd0, 3'd0, 2'd0, 16'h0, 1, 0, 0, "R7");            // idle completion ignored
        do_cyc(6'd37, 3'd0, 2'd1, 16'h0, 1, 1, 1, "R7");           // start beats completion
        do_cyc(6'd37, 3'd0, 2'd2, 16'h0, 1, 0, 0, "R7");           // clear beats completion
        do_cyc(6'd37, 3'd0, 2'd1, 16'h0, 0, 0, 0, "R4");
        do_cyc(6'd0, 3'd0, 2'd0, 16'h0, 1, 0, 0, "R8");            // enabled completion
        do_cyc(6'd37, 3'd7, 2'd1, 16'h0, 0, 0, 0, "R10");          // sense code is no start
        do_cyc(6'd37, 3'd1, 2'd1, 16'h0, 0, 0, 0, "R4");           // read + start clears irq
        do_cyc(6'd37, 3'd6, 2'd2, 16'h0C0C, 0, 0, 0, "R11");       // write + clear
        do_cyc(6'd37, 3'd2, 2'd3, 16'hFFFF, 0, 0, 0, "R6");        // write + pulse

        do_cyc(6'd63, 3'd6, 2'd0, 16'h7777, 0, 0, 0, "R3");        // absent register C
        do_cyc(6'd63, 3'd5, 2'd0, 16'h0, 0, 0, 0, "R3");
        do_cyc(6'd63, 3'd2, 2'd0, 16'hA5A5, 0, 0, 0, "R1");
        do_cyc(6'd63, 3'd1, 2'd0, 16'h0, 0, 0, 0, "R1");
        do_cyc(6'd63, 3'd4, 2'd0, 16'h0F0F, 0, 0, 0, "R2");
        do_cyc(6'd63, 3'd3, 2'd0, 16'h0, 0, 0, 0, "R2");
        do_cyc(6'd37, 3'd5, 2'd0, 16'h0, 0, 0, 0, "R1");

        @(negedge clk);
        bus_cyc = 0; dev_cmpl = 0; mask_ld = 0;
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule